// File: doc/BRIEF.md
# Serial SRAM SPI Host Controller

This block is the host side of an SPI link to a byte-addressed serial SRAM. A client hands it one request at a time: an operation (array read, array write, mode-register read, mode-register write), a start address and a byte count. The block then runs the whole exchange inside one chip-select window. It sends a command byte, then for array operations a 16-bit address, and then the data bytes. Write bytes are pulled from a valid/ready stream, and read bytes are returned with a one-cycle valid strobe.

The serial clock is derived from the system clock. Each half period lasts `HALF_DIV` system clocks, and the clock rests low between transfers. The client can pause a running exchange through `pause_req`. The block then lowers the hold line at a point where the serial clock is low, keeps chip select asserted, and resumes where it stopped once the request is withdrawn. If write data runs dry, the serial clock is parked low until the next byte arrives.

Top module: `sram_spi_host`

## Requirements
- R1: After reset, `spi_cs_n`=1, `spi_sck`=0, `spi_hold_n`=1, `busy`=0, `req_ready`=1 and `rd_valid`=0.
- R2: The first byte in every chip-select window is the command byte, shifted out most significant bit first. Its value depends on `req_op`: 0 (array read) sends 0x03, 1 (array write) sends 0x02, 2 (mode read) sends 0x05 and 3 (mode write) sends 0x01.
- R3: An array operation sends the command, then a 16-bit address with bit 15 forced to 0 and bits 14..0 taken from `req_addr`, then `req_len` data bytes, all in one window. A `req_len` of 0 moves one byte.
- R4: `spi_mosi` changes only while `spi_sck` is low, and `spi_miso` is sampled on the rising serial edge. `spi_sck` is low whenever chip select is high. Each serial half period is `HALF_DIV` system clocks.
- R5: A mode read or mode write moves exactly one data byte, whatever `req_len` holds. Mode-write data comes from the write stream.
- R6: Each received data byte is presented on `rd_data` with a one-cycle `rd_valid` pulse, in the order the bytes arrive.
- R7: `busy` is high from request acceptance until chip select rises. While `busy` is high, `req_ready` is 0 and a `req_valid` starts nothing.
- R8: Between two windows, chip select stays high for at least 2·`HALF_DIV` system clocks.
- R9: When a write byte is due and `wr_valid` is low, `spi_sck` stays low and chip select stays asserted until data is offered. No bits are lost.
- R10: While `pause_req` is high during a transfer, `spi_hold_n` goes low. It changes only while `spi_sck` is low, and chip select stays low for the whole pause. After release, the transfer resumes with no loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_op | input | 2 | Operation code (see R2) |
| req_addr | input | 16 | Start address |
| req_len | input | LEN_W | Data byte count for array operations |
| wr_valid | input | 1 | Write byte offered |
| wr_data | input | 8 | Write byte |
| wr_ready | output | 1 | Write byte taken this cycle when high with wr_valid |
| rd_valid | output | 1 | Received byte strobe |
| rd_data | output | 8 | Received byte |
| busy | output | 1 | Transaction in progress |
| pause_req | input | 1 | Request to pause the serial exchange |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the memory |
| spi_miso | input | 1 | Serial data from the memory |
| spi_hold_n | output | 1 | Hold line, active low |

## Verification
The hardest states to reach from the ports are the two mid-window suspensions: a stall for missing write data and a hold pause in the middle of a read burst. Each must happen with chip select still low and the serial clock parked low. The bench gates its write-data feeder until the controller has finished the address bytes and then counts serial clock highs across the stall. For the pause, it watches the bit count of a bus-level memory model and raises `pause_req` part-way through a data byte. The read data that follows must still match the scoreboard byte for byte.

// File: rtl/sram_spi_pkg.sv
package sram_spi_pkg;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_SREAD  = 2'd2,
    OP_SWRITE = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RUN, ST_PAUSE, ST_STALL, ST_TAIL, ST_GAP
  } st_e;

  typedef enum logic [1:0] {
    PH_CMD, PH_AHI, PH_ALO, PH_DATA
  } ph_e;

  function automatic logic [7:0] cmd_code(op_e op);
    case (op)
      OP_READ:   return 8'h03;
      OP_WRITE:  return 8'h02;
      OP_SREAD:  return 8'h05;
      default:   return 8'h01;
    endcase
  endfunction

  function automatic logic is_status(op_e op);
    return op == OP_SREAD || op == OP_SWRITE;
  endfunction

  function automatic logic is_rx(op_e op);
    return op == OP_READ || op == OP_SREAD;
  endfunction

  function automatic ph_e next_phase(ph_e ph, logic status);
    case (ph)
      PH_CMD:  return status ? PH_DATA : PH_AHI;
      PH_AHI:  return PH_ALO;
      default: return PH_DATA;
    endcase
  endfunction

  // address byte for a phase; bit 15 is always sent as zero
  function automatic logic [7:0] addr_byte(ph_e ph, logic [14:0] a);
    return (ph == PH_AHI) ? {1'b0, a[14:8]} : a[7:0];
  endfunction

endpackage

// File: rtl/sram_spi_clkdiv.sv
module sram_spi_clkdiv #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || tick) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sram_spi_shift.sv
module sram_spi_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [DW-1:0] ld_byte,
  input  logic          fall,
  input  logic          rise,
  input  logic          miso,
  output logic          mosi,
  output logic          bit_last,
  output logic [DW-1:0] rx_next
);
  localparam int BCW = $clog2(DW);

  logic [DW-1:0]  tx_q, rx_q;
  logic [BCW-1:0] bit_q;

  assign mosi     = tx_q[DW-1];
  assign bit_last = (bit_q == BCW'(DW - 1));
  assign rx_next  = {rx_q[DW-2:0], miso};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      bit_q <= '0;
    end else begin
      if (ld) begin
        tx_q  <= ld_byte;
        bit_q <= '0;
      end else if (fall) begin
        tx_q  <= {tx_q[DW-2:0], 1'b0};
        bit_q <= bit_q + 1'b1;
      end
      if (rise) rx_q <= rx_next;
    end
  end

  // R4 serial output only moves on the falling serial edge or a byte load
  tx_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ld) && !$past(fall)) |-> $stable(mosi));
endmodule

// File: rtl/sram_spi_host.sv
module sram_spi_host
  import sram_spi_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int LEN_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [15:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  output logic             wr_ready,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             busy,
  input  logic             pause_req,
  output logic             spi_cs_n,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             spi_hold_n
);
  st_e             st_q, st_d;
  ph_e             ph_q, ph_nx;
  op_e             op_q;
  logic [14:0]     addr_q;
  logic [LEN_W-1:0] left_q;
  logic            sck_q, hold_n_q, gap_q;
  logic            rd_valid_q;
  logic [7:0]      rd_data_q;

  logic tick, clr, ld, bit_last;
  logic [7:0] ld_byte, rx_next;

  // named events shared by the FSM and the assertions
  logic run_tick, rise_ev, fall_ev, pause_ev, resume_ev, byte_end, last_byte, need_wr;

  assign run_tick  = (st_q == ST_RUN) && tick;
  assign rise_ev   = run_tick && !sck_q && !pause_req;
  assign pause_ev  = run_tick && !sck_q && pause_req;
  assign fall_ev   = run_tick && sck_q;
  assign resume_ev = (st_q == ST_PAUSE) && tick && !pause_req;
  assign byte_end  = fall_ev && bit_last;
  assign last_byte = (ph_q == PH_DATA) && (left_q == LEN_W'(1));
  assign ph_nx     = next_phase(ph_q, is_status(op_q));
  assign need_wr   = (ph_nx == PH_DATA) && !is_rx(op_q);
  assign clr       = (st_d != st_q) || (st_q == ST_IDLE);

  sram_spi_clkdiv #(.HALF_DIV(HALF_DIV)) div_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick));

  sram_spi_shift #(.DW(8)) shf_i (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_byte(ld_byte),
    .fall(fall_ev), .rise(rise_ev), .miso(spi_miso),
    .mosi(spi_mosi), .bit_last(bit_last), .rx_next(rx_next));

  always_comb begin
    st_d     = st_q;
    ld       = 1'b0;
    ld_byte  = 8'h00;
    wr_ready = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        st_d    = ST_RUN;
        ld      = 1'b1;
        ld_byte = cmd_code(op_e'(req_op));
      end
      ST_RUN: begin
        if (pause_ev) st_d = ST_PAUSE;
        else if (byte_end) begin
          if (last_byte) st_d = ST_TAIL;
          else if (need_wr) begin
            if (wr_valid) begin
              ld = 1'b1; ld_byte = wr_data; wr_ready = 1'b1;
            end else st_d = ST_STALL;
          end else begin
            ld      = 1'b1;
            ld_byte = (ph_nx == PH_DATA) ? 8'h00 : addr_byte(ph_nx, addr_q);
          end
        end
      end
      ST_PAUSE: if (resume_ev) st_d = ST_RUN;
      ST_STALL: begin
        wr_ready = 1'b1;
        if (wr_valid) begin
          ld = 1'b1; ld_byte = wr_data; st_d = ST_RUN;
        end
      end
      ST_TAIL:  if (tick) st_d = ST_GAP;
      ST_GAP:   if (tick && gap_q) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      ph_q       <= PH_CMD;
      op_q       <= OP_READ;
      addr_q     <= '0;
      left_q     <= '0;
      sck_q      <= 1'b0;
      hold_n_q   <= 1'b1;
      gap_q      <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && req_valid) begin
        op_q   <= op_e'(req_op);
        addr_q <= req_addr[14:0];
        ph_q   <= PH_CMD;
        left_q <= (is_status(op_e'(req_op)) || req_len == '0) ? LEN_W'(1) : req_len;
      end else if (byte_end && !last_byte) begin
        ph_q <= ph_nx;
      end
      if (byte_end && ph_q == PH_DATA) left_q <= left_q - 1'b1;
      if (rise_ev)      sck_q <= 1'b1;
      else if (fall_ev) sck_q <= 1'b0;
      if (pause_ev)       hold_n_q <= 1'b0;
      else if (resume_ev) hold_n_q <= 1'b1;
      if (st_q != ST_GAP) gap_q <= 1'b0;
      else if (tick)      gap_q <= 1'b1;
      rd_valid_q <= rise_ev && bit_last && ph_q == PH_DATA && is_rx(op_q);
      if (rise_ev && bit_last) rd_data_q <= rx_next;
    end
  end

  assign spi_cs_n   = (st_q == ST_IDLE) || (st_q == ST_GAP);
  assign busy       = !spi_cs_n;
  assign req_ready  = (st_q == ST_IDLE);
  assign spi_sck    = sck_q;
  assign spi_hold_n = hold_n_q;
  assign rd_valid   = rd_valid_q;
  assign rd_data    = rd_data_q;

  // R4
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  // R4
  mosi_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));
  // R10
  hold_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_hold_n) |-> !spi_sck);
  // R10
  hold_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_hold_n |-> !spi_cs_n);
  // R7
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  // R8
  gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> spi_cs_n);
  // R9
  stall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STALL) |-> (!spi_sck && !spi_cs_n));
  // R6
  rdv_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !spi_cs_n);
endmodule

// File: tb/sram_spi_host_tb.sv
module sram_spi_host_tb_top;
  localparam int HALF = 2;
  localparam int LW   = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic [15:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic wr_valid = 1'b0, wr_ready;
  logic [7:0] wr_data = '0;
  logic rd_valid, busy, pause_req = 1'b0;
  logic [7:0] rd_data;
  logic spi_cs_n, spi_sck, spi_mosi, spi_hold_n;
  logic spi_miso = 1'b0;

  always #2 clk = ~clk;

  sram_spi_host #(.HALF_DIV(HALF), .LEN_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .pause_req(pause_req),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_hold_n(spi_hold_n));

  int checks = 0, fails = 0;
  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // bus-level memory model
  logic [7:0] mem [256];
  logic [7:0] sh  [256];
  logic [7:0] m_sh = '0, m_cmd = '0, m_sreg = '0;
  logic [15:0] m_addr = '0;
  int m_bits = 0, cs_falls = 0;

  always @(negedge spi_cs_n) begin m_bits = 0; m_cmd = 8'h00; cs_falls++; end

  always @(posedge spi_sck) if (!spi_cs_n && spi_hold_n) begin
    int k;
    m_sh = {m_sh[6:0], spi_mosi};
    m_bits++;
    if (m_bits % 8 == 0) begin
      k = m_bits / 8 - 1;
      if (k == 0) m_cmd = m_sh;
      else if (m_cmd == 8'h02 || m_cmd == 8'h03) begin
        if (k == 1) m_addr[15:8] = m_sh;
        else if (k == 2) m_addr[7:0] = m_sh;
        else if (m_cmd == 8'h02) mem[8'(m_addr + 16'(k - 3))] = m_sh;
      end else if (m_cmd == 8'h01 && k == 1) m_sreg = m_sh;
    end
  end

  always @(negedge spi_sck) if (!spi_cs_n) begin
    logic [7:0] b;
    if (m_cmd == 8'h03 && m_bits >= 24) begin
      b = mem[8'(m_addr + 16'((m_bits - 24) / 8))];
      spi_miso = b[7 - (m_bits % 8)];
    end else if (m_cmd == 8'h05 && m_bits >= 8) begin
      spi_miso = m_sreg[7 - (m_bits % 8)];
    end
  end

  // write-data feeder
  logic [7:0] wq[$];
  bit wr_gate = 1'b0;
  initial forever begin
    bit hs;
    @(posedge clk); hs = wr_valid && wr_ready;
    @(negedge clk);
    if (hs) void'(wq.pop_front());
    wr_valid = (wq.size() > 0) && !wr_gate;
    wr_data  = (wq.size() > 0) ? wq[0] : 8'h00;
  end

  // scoreboard monitor
  logic [7:0] exp_q[$];
  string exp_tag[$];
  initial forever begin
    @(negedge clk);
    if (rd_valid) begin
      if (exp_q.size() == 0) chk(0, "R6 unexpected rd_valid", rd_data, 0);
      else begin
        logic [7:0] e; string t;
        e = exp_q.pop_front(); t = exp_tag.pop_front();
        chk(rd_data == e, t, rd_data, e);
      end
    end
  end

  // chip-select high time monitor
  int hi_run = 0, min_gap = 1000;
  bit seen_low = 0;
  initial forever begin
    @(negedge clk);
    if (spi_cs_n) hi_run++;
    else begin
      if (seen_low && hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
      hi_run = 0; seen_low = 1;
    end
  end

  task automatic issue(int op, logic [15:0] a, int len);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_addr = a; req_len = LW'(len);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    repeat (2) @(negedge clk);
    while (busy || !req_ready) @(negedge clk);
  endtask

  task automatic do_write(logic [15:0] a, int len, logic [7:0] seed);
    int n; n = (len == 0) ? 1 : len;
    for (int i = 0; i < n; i++) begin
      wq.push_back(seed + 8'(i * 17));
      sh[8'(a[14:0] + 15'(i))] = seed + 8'(i * 17);
    end
    issue(1, a, len);
  endtask

  task automatic do_read(logic [15:0] a, int len, string tag);
    for (int i = 0; i < len; i++) begin
      exp_q.push_back(sh[8'(a[14:0] + 15'(i))]);
      exp_tag.push_back(tag);
    end
    issue(0, a, len);
  endtask

  initial begin
    #400000;
    chk(0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int f0, hi_cnt, b0;
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i * 7 + 3); sh[i] = 8'(i * 7 + 3); end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(spi_cs_n && !spi_sck && spi_hold_n && !busy && req_ready && !rd_valid,
        "R1 reset outputs", {spi_cs_n, spi_sck, spi_hold_n, busy, req_ready}, 5'b10101);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 burst write with bit 15 set in the request
    do_write(16'h8010, 4, 8'hA0);
    wait_done();
    chk(m_cmd == 8'h02, "R2 write command", m_cmd, 8'h02);
    chk(m_addr == 16'h0010, "R3 address bit15 forced 0", m_addr, 16'h0010);
    chk(m_bits == 24 + 32, "R3 four data bytes in one window", m_bits, 56);

    // R6 read back through the scoreboard
    do_read(16'h0010, 4, "R6 burst read data");
    wait_done();
    chk(m_cmd == 8'h03, "R2 read command", m_cmd, 8'h03);

    // R5 mode register write/read, req_len ignored
    wq.push_back(8'h41);
    issue(3, 16'h0000, 9);
    wait_done();
    chk(m_cmd == 8'h01 && m_sreg == 8'h41, "R5 mode write", m_sreg, 8'h41);
    chk(m_bits == 16, "R5 mode write one byte", m_bits, 16);
    exp_q.push_back(8'h41); exp_tag.push_back("R5 mode read data");
    issue(2, 16'h0000, 5);
    wait_done();
    chk(m_cmd == 8'h05 && m_bits == 16, "R2 R5 mode read command/length", m_bits, 16);

    // R3 zero length moves one byte
    do_write(16'h0050, 0, 8'h5A);
    wait_done();
    chk(m_bits == 32 && mem[8'h50] == 8'h5A, "R3 len0 one byte", m_bits, 32);

    // R9 write data stall
    wr_gate = 1'b1;
    do_write(16'h0040, 2, 8'hC3);
    repeat (150) @(negedge clk);
    hi_cnt = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (spi_sck || spi_cs_n) hi_cnt++; end
    chk(hi_cnt == 0, "R9 sck parked low, cs held", hi_cnt, 0);
    chk(m_bits == 24, "R9 no bits during stall", m_bits, 24);
    wr_gate = 1'b0;
    wait_done();
    chk(mem[8'h40] == 8'hC3 && mem[8'h41] == 8'(8'hC3 + 17), "R9 data after stall", mem[8'h40], 8'hC3);

    // R7 refusal while busy, during a read of the stalled data
    f0 = cs_falls;
    do_read(16'h0040, 2, "R6 R9 read after stall");
    repeat (10) @(negedge clk);
    hi_cnt = 0;
    req_op = 2'd1; req_valid = 1'b1;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (req_ready || !busy) hi_cnt++; end
    req_valid = 1'b0;
    chk(hi_cnt == 0, "R7 ready low while busy", hi_cnt, 0);
    wait_done();
    chk(cs_falls == f0 + 1 && m_cmd == 8'h03, "R7 refused request ignored", cs_falls - f0, 1);

    // R10 pause in mid data byte
    do_read(16'h0020, 6, "R10 read across pause");
    while (m_bits < 37) @(negedge clk);
    pause_req = 1'b1;
    repeat (20) @(negedge clk);
    b0 = m_bits;
    chk(!spi_hold_n && !spi_cs_n && !spi_sck, "R10 paused outputs",
        {spi_hold_n, spi_cs_n, spi_sck}, 3'b000);
    repeat (30) @(negedge clk);
    chk(m_bits == b0 && !spi_cs_n, "R10 no clocks during pause", m_bits, b0);
    pause_req = 1'b0;
    wait_done();
    chk(spi_hold_n && m_bits == 24 + 48, "R10 resume completes", m_bits, 72);

    // R8 back-to-back transactions
    do_read(16'h0000, 1, "R8 b2b read A");
    do_read(16'h0001, 1, "R8 b2b read B");
    wait_done();
    chk(min_gap >= 2 * HALF, "R8 cs high gap", min_gap, 2 * HALF);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all reads returned", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule